// File: doc/BRIEF.md
# Sealed Capability Domain-Call Unit

This unit performs a cross-domain call in a capability processor without taking an exception. The issue stage hands it two sealed capabilities from the register file. One is a code handle and the other is a data handle. The unit checks that the pair authorises the call. If it does, the unit unseals both handles and installs them in one clock edge: the code handle goes to the program-counter capability (PCC) and the data handle goes to the default-data capability (DDC). The unsealed data handle acts as the callee's link value. The unit has no delay slot. The instruction that follows the call in program order is always squashed. No cycle ever shows the new DDC while the PCC still holds the caller's capability.

The control is a four-state machine:
- `S_IDLE`: ready for a request.
- `S_CHECK`: the latched operands are validated.
- `S_COMMIT`: a one-cycle announcement of a successful call.
- `S_FAULT`: a one-cycle announcement of a rejected call.

The transitions are:
- `S_IDLE` to `S_CHECK` (accept) when `req_valid_i` and `req_ready_o` are both high.
- `S_CHECK` to `S_COMMIT` (pass) when validation succeeds and no interrupt is pending.
- `S_CHECK` to `S_FAULT` (reject) when validation fails and no interrupt is pending.
- `S_CHECK` to `S_IDLE` (abandon) when an interrupt is pending. The interrupt is taken before the call commits, so the call must be reissued later.
- `S_COMMIT` to `S_IDLE` and `S_FAULT` to `S_IDLE` (retire) unconditionally.

Each capability is 33 bits wide. From the most significant bit down, the fields are:
- tag [32]
- sealed [31]
- object type [30:28]
- permissions [27:24]
- base [23:16]
- length [15:8]
- address [7:0]

Top module: `dcall_unit`

## Requirements
- R1: The capability fields are placed as follows: tag bit 32, sealed bit 31, object type [30:28], permissions [27:24], address [7:0]. If either operand has tag 0, the call fails with cause 1. This check has the highest priority.
- R2: If both tags are 1 and either operand has sealed 0, the call fails with cause 2.
- R3: If both operands are tagged and sealed but their object types differ, the call fails with cause 3.
- R4: Permission bit 24 means execute and bit 25 means call-allowed. The code operand must have both bits. The data operand must have call-allowed and must not have execute. If any of these checks fails after R1 to R3 have passed, the call fails with cause 4.
- R5: A passing call commits two cycles after acceptance. In the commit cycle, `commit_o` and `redirect_valid_o` are high, and `redirect_pc_o` equals the code operand's address. PCC and DDC hold the new values from that same cycle onward.
- R6: Unsealing keeps every field of a capability except two: sealed becomes 0 and the object type becomes 7.
- R7: A failing call raises `fault_o` for one cycle, two cycles after acceptance, with the cause on `fault_cause_o`. PCC and DDC stay unchanged. Outside a fault, the cause reads 0.
- R8: In both the commit cycle and the fault cycle, `squash_o` is high. The younger instruction is discarded and no delay slot exists.
- R9: During the check cycle, neither PCC nor DDC has changed and neither strobe is high. PCC and DDC only ever change on the same edge.
- R10: In `S_IDLE`, a high `irq_i` raises `irq_take_o` and drops `req_ready_o`.
- R11: A high `irq_i` during the check cycle raises `irq_take_o` and abandons the call. No commit or fault follows, and PCC and DDC stay unchanged.
- R12: During the commit and fault cycles, `irq_take_o` stays low. A request still held is taken in the next cycle.
- R13: After reset, PCC and DDC are all zeros, `req_ready_o` is high, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Issue stage presents a call |
| req_ready_o | output | 1 | Unit accepts a call this cycle |
| code_cap_i | input | 33 | Sealed code capability operand |
| data_cap_i | input | 33 | Sealed data capability operand |
| irq_i | input | 1 | Pending interrupt request |
| irq_take_o | output | 1 | Interrupt accepted at this instruction boundary |
| pcc_o | output | 33 | Program-counter capability |
| ddc_o | output | 33 | Default-data capability |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 8 | Fetch redirect target |
| commit_o | output | 1 | Call committed this cycle |
| squash_o | output | 1 | Discard younger in-flight instructions |
| fault_o | output | 1 | Call rejected this cycle |
| fault_cause_o | output | 3 | Rejection cause |

## Verification
The commit or fault strobe, its cause, and the new PCC and DDC values are all due in the second cycle after the edge that accepts a request. The check cycle between those two edges must show no change at all. The bench drives inputs on falling edges. It samples the check-cycle state one falling edge after acceptance and the result one falling edge later. Interrupt acceptance is combinational, so it is read a short delay after the interrupt input is driven, within the same cycle.

// File: rtl/dcall_pkg.sv
package dcall_pkg;
    parameter int ADDR_W  = 8;
    parameter int OTYPE_W = 3;
    parameter int PERM_W  = 4;

    localparam int PERM_EXEC = 0;
    localparam int PERM_CALL = 1;
    localparam logic [OTYPE_W-1:0] OTYPE_UNSEALED = '1;

    typedef struct packed {
        logic               tag;
        logic               sealed;
        logic [OTYPE_W-1:0] otype;
        logic [PERM_W-1:0]  perms;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  len;
        logic [ADDR_W-1:0]  addr;
    } cap_t;

    localparam int CAP_W = $bits(cap_t);

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_TAG  = 3'd1,
        CAUSE_SEAL = 3'd2,
        CAUSE_TYPE = 3'd3,
        CAUSE_PERM = 3'd4
    } cause_e;

    // R6: only the sealed flag and object type change on unsealing.
    function automatic cap_t unseal(cap_t c);
        cap_t r;
        r        = c;
        r.sealed = 1'b0;
        r.otype  = OTYPE_UNSEALED;
        return r;
    endfunction
endpackage

// File: rtl/dcall_validate.sv
module dcall_validate
    import dcall_pkg::*;
(
    input  logic               code_tag_i,
    input  logic               code_sealed_i,
    input  logic [OTYPE_W-1:0] code_otype_i,
    input  logic               code_exec_i,
    input  logic               code_call_i,
    input  logic               data_tag_i,
    input  logic               data_sealed_i,
    input  logic [OTYPE_W-1:0] data_otype_i,
    input  logic               data_exec_i,
    input  logic               data_call_i,
    output logic               pass_o,
    output cause_e             cause_o
);
    // Priority order (R1..R4): tag, seal, type, permission.
    always_comb begin
        if (!code_tag_i || !data_tag_i) begin
            cause_o = CAUSE_TAG;
        end else if (!code_sealed_i || !data_sealed_i) begin
            cause_o = CAUSE_SEAL;
        end else if (code_otype_i != data_otype_i) begin
            cause_o = CAUSE_TYPE;
        end else if (!code_exec_i || !code_call_i || !data_call_i || data_exec_i) begin
            cause_o = CAUSE_PERM;
        end else begin
            cause_o = CAUSE_NONE;
        end
        pass_o = (cause_o == CAUSE_NONE);
    end
endmodule

// File: rtl/dcall_domain_regs.sv
module dcall_domain_regs #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] pcc_d,
    input  logic [W-1:0] ddc_d,
    output logic [W-1:0] pcc_q,
    output logic [W-1:0] ddc_q
);
    // Both domain registers share one load enable: a single atomic swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcc_q <= '0;
            ddc_q <= '0;
        end else if (ld_i) begin
            pcc_q <= pcc_d;
            ddc_q <= ddc_d;
        end
    end

    assert_ddc_only_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ddc_q != $past(ddc_q)) |-> $past(ld_i));
    assert_pcc_only_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pcc_q != $past(pcc_q)) |-> $past(ld_i));
endmodule

// File: rtl/dcall_unit.sv
module dcall_unit
    import dcall_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [CAP_W-1:0]   code_cap_i,
    input  logic [CAP_W-1:0]   data_cap_i,
    input  logic               irq_i,
    output logic               irq_take_o,
    output logic [CAP_W-1:0]   pcc_o,
    output logic [CAP_W-1:0]   ddc_o,
    output logic               redirect_valid_o,
    output logic [ADDR_W-1:0]  redirect_pc_o,
    output logic               commit_o,
    output logic               squash_o,
    output logic               fault_o,
    output logic [2:0]         fault_cause_o
);
    typedef enum logic [1:0] {S_IDLE, S_CHECK, S_COMMIT, S_FAULT} state_e;

    state_e state_q, state_d;
    cap_t   code_q, data_q, pcc_c;
    cause_e cause_q, chk_cause;
    logic   chk_pass, accept, load;

    dcall_validate u_validate (
        .code_tag_i    (code_q.tag),
        .code_sealed_i (code_q.sealed),
        .code_otype_i  (code_q.otype),
        .code_exec_i   (code_q.perms[PERM_EXEC]),
        .code_call_i   (code_q.perms[PERM_CALL]),
        .data_tag_i    (data_q.tag),
        .data_sealed_i (data_q.sealed),
        .data_otype_i  (data_q.otype),
        .data_exec_i   (data_q.perms[PERM_EXEC]),
        .data_call_i   (data_q.perms[PERM_CALL]),
        .pass_o        (chk_pass),
        .cause_o       (chk_cause)
    );

    dcall_domain_regs #(.W(CAP_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_i  (load),
        .pcc_d (unseal(code_q)),
        .ddc_d (unseal(data_q)),
        .pcc_q (pcc_o),
        .ddc_q (ddc_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Operand and cause latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            data_q  <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            if (accept) begin
                code_q <= cap_t'(code_cap_i);
                data_q <= cap_t'(data_cap_i);
            end
            if (state_q == S_CHECK && !irq_i && !chk_pass) cause_q <= chk_cause;
        end
    end

    assign pcc_c         = cap_t'(pcc_o);
    assign redirect_pc_o = pcc_c.addr;

    // Next state and outputs
    always_comb begin
        state_d          = state_q;
        req_ready_o      = 1'b0;
        irq_take_o       = 1'b0;
        accept           = 1'b0;
        load             = 1'b0;
        commit_o         = 1'b0;
        redirect_valid_o = 1'b0;
        squash_o         = 1'b0;
        fault_o          = 1'b0;
        fault_cause_o    = CAUSE_NONE;
        unique case (state_q)
            S_IDLE: begin
                irq_take_o  = irq_i;
                req_ready_o = !irq_i;
                accept      = req_valid_i && !irq_i;
                if (accept) state_d = S_CHECK;
            end
            S_CHECK: begin
                if (irq_i) begin
                    irq_take_o = 1'b1;
                    state_d    = S_IDLE;
                end else if (chk_pass) begin
                    load    = 1'b1;
                    state_d = S_COMMIT;
                end else begin
                    state_d = S_FAULT;
                end
            end
            S_COMMIT: begin
                commit_o         = 1'b1;
                redirect_valid_o = 1'b1;
                squash_o         = 1'b1;
                state_d          = S_IDLE;
            end
            S_FAULT: begin
                fault_o       = 1'b1;
                fault_cause_o = cause_q;
                squash_o      = 1'b1;
                state_d       = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assert_commit_squashes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || fault_o) |-> squash_o);
    assert_commit_after_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(state_q) == S_CHECK && pcc_c.sealed == 1'b0));
    assert_fault_keeps_domain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(pcc_o) && $stable(ddc_o)));
    assert_irq_abandons_call_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take_o && state_q == S_CHECK) |=> (!commit_o && !fault_o));
    assert_no_irq_in_retire_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || fault_o) |-> !irq_take_o);
endmodule

// File: tb/dcall_unit_bench.sv
module dcall_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [32:0] code_cap = '0;
    logic [32:0] data_cap = '0;
    logic        irq = 1'b0;
    logic        irq_take;
    logic [32:0] pcc, ddc;
    logic        redirect_valid;
    logic [7:0]  redirect_pc;
    logic        commit, squash, fault;
    logic [2:0]  fault_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [32:0] m_pcc = '0;
    logic [32:0] m_ddc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcall_unit u_dcall_unit (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .code_cap_i(code_cap), .data_cap_i(data_cap), .irq_i(irq), .irq_take_o(irq_take),
        .pcc_o(pcc), .ddc_o(ddc), .redirect_valid_o(redirect_valid),
        .redirect_pc_o(redirect_pc), .commit_o(commit), .squash_o(squash),
        .fault_o(fault), .fault_cause_o(fault_cause)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] mk(input bit t, input bit s, input int ot, input int pm, input int ad);
        return {t, s, 3'(ot), 4'(pm), 8'h10, 8'h40, 8'(ad)};
    endfunction

    function automatic int exp_cause(input logic [32:0] c, input logic [32:0] d);
        if (!c[32] || !d[32]) return 1;
        if (!c[31] || !d[31]) return 2;
        if (c[30:28] != d[30:28]) return 3;
        if (!c[24] || !c[25] || !d[25] || d[24]) return 4;
        return 0;
    endfunction

    function automatic logic [32:0] unsealed(input logic [32:0] c);
        return {c[32], 1'b0, 3'b111, c[27:0]};
    endfunction

    // mode 0: plain, 1: irq in check cycle, 2: irq held during retire cycle
    task automatic do_call(input logic [32:0] c, input logic [32:0] d, input int mode);
        int ec;
        @(negedge clk);
        code_cap = c; data_cap = d; req_valid = 1'b1;
        #1 chk(req_ready == 1'b1, "R13 ready in idle", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!commit && !fault, "R9 no strobe in check cycle", {62'd0, commit, fault}, 64'd0);
        chk(pcc == m_pcc && ddc == m_ddc, "R9 domain unchanged in check cycle", 64'(ddc), 64'(m_ddc));
        if (mode == 1) begin
            irq = 1'b1;
            #1 chk(irq_take == 1'b1, "R11 irq taken in check", 64'(irq_take), 64'd1);
            @(posedge clk);
            @(negedge clk);
            irq = 1'b0;
            chk(!commit && !fault, "R11 call abandoned", {62'd0, commit, fault}, 64'd0);
            chk(pcc == m_pcc && ddc == m_ddc, "R11 domain unchanged", 64'(pcc), 64'(m_pcc));
            return;
        end
        @(posedge clk);
        @(negedge clk);
        ec = exp_cause(c, d);
        if (ec == 0) begin
            m_pcc = unsealed(c);
            m_ddc = unsealed(d);
            chk(commit && redirect_valid && !fault, "R5 commit strobe", {61'd0, commit, redirect_valid, fault}, 64'b110);
            chk(redirect_pc == c[7:0], "R5 redirect target", 64'(redirect_pc), 64'(c[7:0]));
            chk(pcc == m_pcc, "R6 unsealed PCC", 64'(pcc), 64'(m_pcc));
            chk(ddc == m_ddc, "R6 unsealed DDC", 64'(ddc), 64'(m_ddc));
        end else begin
            chk(fault && !commit, "R7 fault strobe", {62'd0, fault, commit}, 64'b10);
            chk(int'(fault_cause) == ec,
                ec == 1 ? "R1 cause" : ec == 2 ? "R2 cause" : ec == 3 ? "R3 cause" : "R4 cause",
                64'(fault_cause), 64'(ec));
            chk(pcc == m_pcc && ddc == m_ddc, "R7 domain unchanged", 64'(pcc), 64'(m_pcc));
        end
        chk(squash == 1'b1, "R8 squash younger", 64'(squash), 64'd1);
        if (mode == 2) begin
            irq = 1'b1;
            #1 chk(irq_take == 1'b0, "R12 irq held off in retire", 64'(irq_take), 64'd0);
            @(posedge clk);
            @(negedge clk);
            chk(irq_take && !req_ready, "R10 irq taken in idle", {62'd0, irq_take, req_ready}, 64'b10);
            irq = 1'b0;
        end else begin
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(pcc == '0 && ddc == '0, "R13 reset domain", 64'(pcc), 64'd0);
        chk(!commit && !fault && !squash && fault_cause == 3'd0, "R13 reset strobes",
            {61'd0, commit, fault, squash}, 64'd0);
        // tag x seal combinations
        for (int i = 0; i < 16; i++)
            do_call(mk(i[0], i[2], 2, 4'b0011, i), mk(i[1], i[3], 2, 4'b0110, 0), 0);
        // object type pairs
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++)
                do_call(mk(1, 1, a, 4'b1011, a * 7 + b), mk(1, 1, b, 4'b0010, b), 0);
        // permission sweep
        for (int p = 0; p < 16; p++)
            for (int q = 0; q < 16; q++)
                do_call(mk(1, 1, 5, p, p * 16 + q), mk(1, 1, 5, q, q), 0);
        // interrupt orderings
        do_call(mk(1, 1, 3, 4'b0011, 8'hA5), mk(1, 1, 3, 4'b0010, 8'h5A), 1);
        do_call(mk(1, 1, 3, 4'b0011, 8'hC3), mk(1, 1, 3, 4'b0010, 8'h3C), 2);
        do_call(mk(1, 0, 3, 4'b0011, 8'h11), mk(1, 1, 3, 4'b0010, 8'h22), 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule